// File: doc/BRIEF.md
# Single-Wire Bus Bit-Slot Timer

This block is the bottom layer of a master for a single-wire, open-drain, bidirectional bus. It is asked for one time slot at a time through a valid/ready request port: a bus reset with presence detect, a write of 0, a write of 1, a read, or a "touch" that writes and reads in one slot. It produces the pull-low enable for the external open-drain driver, samples the line at a fixed point inside the slot, and hands back the sampled bit or the presence result with a one-cycle done pulse.

All slot timing is counted from an external 1 µs tick. Each phase length is a base value in ticks multiplied by an integer coefficient, which is captured when a request is accepted. This lets the same slot shapes be stretched for slow or heavily loaded buses. Byte assembly, device search, CRC and power delivery are handled above this block.

Top module: `owire_slot_engine`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 1 exactly when `busy_o` is 0. `busy_o` rises on the accepting edge and stays high until the slot's last release tick. Requests presented while busy are ignored: they do not change the running slot and are not queued.
- R2: A write of 1 (`req_kind_i` = 2'b01 with `req_bit_i` = 1) holds `pull_low_o` high for 6·k ticks and then releases the line for 64·k ticks before the slot ends. k is the effective coefficient.
- R3: A write of 0 (`req_kind_i` = 2'b01 with `req_bit_i` = 0) holds `pull_low_o` high for 60·k ticks and then releases the line for 10·k ticks.
- R4: A read (`req_kind_i` = 2'b10) holds the line low for 6·k ticks and then releases it. The synchronised line is sampled on the tick that completes 9·k release ticks, and the slot continues for another 55·k ticks. `result_o` is the sampled level.
- R5: A bus reset (`req_kind_i` = 2'b00) holds the line low for 480·k ticks and samples it on the tick that completes 70·k release ticks. The slot then stays idle for another 410·k ticks, so the release phase totals 480·k ticks. `result_o` = 0 means a device answered and 1 means no device answered.
- R6: k is `coef_i` captured at acceptance, with 0 treated as 1. A change of `coef_i` during a slot has no effect on that slot. Phase lengths advance only on clock edges where `tick_i` is 1.
- R7: A touch (`req_kind_i` = 2'b11) with `req_bit_i` = 1 runs exactly as a read and returns the sample. A touch with `req_bit_i` = 0 runs exactly as a write of 0. Both writes and touch-0 return `result_o` = 0 whatever the line level is.
- R8: `done_o` is a one-cycle pulse in the first cycle after the slot's last tick, the same cycle in which `busy_o` is first 0. `result_o` changes only together with `done_o` and holds its value until the next `done_o`.
- R9: After reset the block is idle: `busy_o` = 0, `pull_low_o` = 0, `done_o` = 0, `result_o` = 0. `pull_low_o` is 1 only inside a slot's low phase. The block has no output that drives the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every microsecond |
| coef_i | input | COEF_W | Duration multiplier (0 acts as 1) |
| req_valid_i | input | 1 | Slot request valid |
| req_kind_i | input | 2 | 00 reset, 01 write, 10 read, 11 touch |
| req_bit_i | input | 1 | Write or touch value |
| req_ready_o | output | 1 | Request can be accepted |
| line_i | input | 1 | Raw bus level |
| pull_low_o | output | 1 | Enable of the open-drain pull-down |
| busy_o | output | 1 | Slot in progress |
| done_o | output | 1 | Slot finished, result valid |
| result_o | output | 1 | Sampled bit or presence result |

## Verification
Every slot kind is run with a line model that shows the inverted level on every release tick except the single tick before the intended sample point. A sample taken one tick early or one tick late therefore returns the opposite value. Running this with both polarities separates a correct sample point from a stuck or misplaced one, and separates "device present" from "no device". The low and release ticks are counted on the outputs at coefficients 0, 1, 2, 3 and 4. These counts show whether each phase scales on its own and whether the coefficient is captured at acceptance rather than read live. Writes and touch-0 are run with a line level that would give 1 if sampled, which shows they return 0. A request issued in the middle of a slot checks that it leaves no trace.

// File: rtl/owire_pkg.sv
package owire_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_SMP  = 2'd2,
    ST_REC  = 2'd3
  } state_e;

  typedef enum logic [1:0] {
    OP_RST = 2'd0,
    OP_W0  = 2'd1,
    OP_W1  = 2'd2,
    OP_RD  = 2'd3
  } op_e;

  localparam logic [1:0] KIND_RST   = 2'b00;
  localparam logic [1:0] KIND_WR    = 2'b01;
  localparam logic [1:0] KIND_RD    = 2'b10;
  localparam logic [1:0] KIND_TOUCH = 2'b11;

  function automatic op_e decode_op(input logic [1:0] kind, input logic bit_v);
    case (kind)
      KIND_RST: return OP_RST;
      KIND_WR:  return bit_v ? OP_W1 : OP_W0;
      KIND_RD:  return OP_RD;
      default:  return bit_v ? OP_RD : OP_W0;  // touch-1 is a read
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= RST_VAL;
        else         ff_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/owire_phase_timer.sv
module owire_phase_timer #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // limit_i is never zero: base >= 1 and coefficient >= 1
  assign expire_o = en_i && tick_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i || expire_o) cnt_q <= '0;
    else if (en_i && tick_i)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
  import owire_pkg::*;
#(
  parameter int unsigned COEF_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned W1_LOW      = 6,
  parameter int unsigned W1_REL      = 64,
  parameter int unsigned W0_LOW      = 60,
  parameter int unsigned W0_REL      = 10,
  parameter int unsigned RD_LOW      = 6,
  parameter int unsigned RD_SMP      = 9,
  parameter int unsigned RD_REC      = 55,
  parameter int unsigned RS_LOW      = 480,
  parameter int unsigned RS_SMP      = 70,
  parameter int unsigned RS_REC      = 410
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_bit_i,
  output logic              req_ready_o,
  input  logic              line_i,
  output logic              pull_low_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              result_o
);
  localparam int unsigned MAX_BASE =
    max2(max2(max2(W1_LOW, W1_REL), max2(W0_LOW, W0_REL)),
         max2(max2(max2(RD_LOW, RD_SMP), max2(RD_REC, RS_LOW)), max2(RS_SMP, RS_REC)));
  localparam int unsigned BASE_W = $clog2(MAX_BASE + 1);
  localparam int unsigned DUR_W  = BASE_W + COEF_W;

  state_e            state_q;
  op_e               op_q;
  logic [COEF_W-1:0] coef_q;
  logic              smp_q, result_q, done_q;
  logic              line_s, accept, phase_end;
  logic [BASE_W-1:0] base;
  logic [DUR_W-1:0]  limit;

  assign busy_o      = (state_q != ST_IDLE);
  assign req_ready_o = !busy_o;
  assign accept      = req_valid_i && req_ready_o;
  assign pull_low_o  = (state_q == ST_LOW);
  assign done_o      = done_q;
  assign result_o    = result_q;

  owire_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  always_comb begin
    base = BASE_W'(1);
    case (state_q)
      ST_LOW: case (op_q)
        OP_RST:  base = BASE_W'(RS_LOW);
        OP_W0:   base = BASE_W'(W0_LOW);
        OP_W1:   base = BASE_W'(W1_LOW);
        default: base = BASE_W'(RD_LOW);
      endcase
      ST_SMP: base = (op_q == OP_RST) ? BASE_W'(RS_SMP) : BASE_W'(RD_SMP);
      ST_REC: case (op_q)
        OP_RST:  base = BASE_W'(RS_REC);
        OP_W0:   base = BASE_W'(W0_REL);
        OP_W1:   base = BASE_W'(W1_REL);
        default: base = BASE_W'(RD_REC);
      endcase
      default: base = BASE_W'(1);
    endcase
  end

  assign limit = DUR_W'(base) * DUR_W'(coef_q);

  owire_phase_timer #(.CNT_W(DUR_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (busy_o),
    .clear_i (accept),
    .tick_i  (tick_i),
    .limit_i (limit),
    .expire_o(phase_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_RD;
      coef_q   <= COEF_W'(1);
      smp_q    <= 1'b0;
      result_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_LOW;
        op_q    <= decode_op(req_kind_i, req_bit_i);
        coef_q  <= (coef_i == '0) ? COEF_W'(1) : coef_i;
        smp_q   <= 1'b0;
      end else if (phase_end) begin
        case (state_q)
          ST_LOW: state_q <= (op_q == OP_RST || op_q == OP_RD) ? ST_SMP : ST_REC;
          ST_SMP: begin
            state_q <= ST_REC;
            smp_q   <= line_s;
          end
          ST_REC: begin
            state_q  <= ST_IDLE;
            result_q <= smp_q;  // stays 0 for write slots
            done_q   <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/owire_slot_checker.sv
module owire_slot_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic pull_low_o,
  input logic busy_o,
  input logic done_o,
  input logic result_o
);
  AST_ACCEPT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (busy_o && pull_low_o)); // R1
  AST_BUSY_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> busy_o); // R1
  AST_PHASE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> $stable(pull_low_o)); // R6
  AST_PULL_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_low_o |-> busy_o); // R9
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o)); // R8
endmodule

bind owire_slot_engine owire_slot_checker u_chk (.*);

// File: tb/tb_owire_slot_engine.sv
module tb_owire_slot_engine;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] coef_i = 8'd1;
  logic       req_valid_i = 1'b0;
  logic [1:0] req_kind_i = 2'b00;
  logic       req_bit_i = 1'b0;
  logic       req_ready_o, line_i, pull_low_o, busy_o, done_o, result_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int low_cnt = 0, rel_cnt = 0, smp_at = 0, tdiv = 0;
  logic xval = 1'b0;
  logic fin = 1'b0;

  owire_slot_engine dut (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  always @(negedge clk_i) begin
    tick_i <= (tdiv == 3);
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
  end

  // tick counters seen at the ports
  always @(posedge clk_i) begin
    if (req_valid_i && req_ready_o) begin
      low_cnt <= 0;
      rel_cnt <= 0;
    end else if (tick_i && busy_o) begin
      if (pull_low_o) low_cnt <= low_cnt + 1;
      else            rel_cnt <= rel_cnt + 1;
    end
  end

  // line shows xval only on the release tick before the sample point
  always @(negedge clk_i)
    line_i <= pull_low_o ? 1'b0 :
              ((busy_o && smp_at != 0 && rel_cnt == smp_at - 1) ? xval : !xval);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !fin) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act cycles=%0d exp done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] kind, input logic b, input logic [7:0] c);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_kind_i  = kind;
    req_bit_i   = b;
    coef_i      = c;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_done;
    while (!done_o) @(negedge clk_i);
  endtask

  task automatic slot(input string tag, input logic [1:0] kind, input logic b,
                      input logic [7:0] c, input logic x, input int smp_base,
                      input int e_low, input int e_rel, input int e_res);
    int k;
    k = (c == 0) ? 1 : int'(c);
    xval   = x;
    smp_at = smp_base * k;
    start(kind, b, c);
    wait_done();
    chk({tag, " low ticks"}, low_cnt, e_low * k);
    chk({tag, " release ticks"}, rel_cnt, e_rel * k);
    chk({tag, " result"}, int'(result_o), e_res);
    chk({tag, " busy after done"}, int'(busy_o), 0);
  endtask

  task automatic t_reset_state;
    chk("R9 reset busy", int'(busy_o), 0);
    chk("R9 reset pull", int'(pull_low_o), 0);
    chk("R9 reset done", int'(done_o), 0);
    chk("R9 reset result", int'(result_o), 0);
    chk("R1 reset ready", int'(req_ready_o), 1);
  endtask

  task automatic t_writes;
    slot("R2 write1 k1", 2'b01, 1'b1, 8'd1, 1'b0, 0, 6, 64, 0);
    slot("R2 write1 k3", 2'b01, 1'b1, 8'd3, 1'b0, 0, 6, 64, 0);
    slot("R3 write0 k1", 2'b01, 1'b0, 8'd1, 1'b0, 0, 60, 10, 0);
    slot("R3 write0 k2", 2'b01, 1'b0, 8'd2, 1'b0, 0, 60, 10, 0);
  endtask

  task automatic t_reads;
    slot("R4 read x0 k1", 2'b10, 1'b0, 8'd1, 1'b0, 9, 6, 64, 0);
    slot("R4 read x1 k1", 2'b10, 1'b0, 8'd1, 1'b1, 9, 6, 64, 1);
    slot("R4 read x1 k4", 2'b10, 1'b1, 8'd4, 1'b1, 9, 6, 64, 1);
  endtask

  task automatic t_bus_reset;
    slot("R5 reset present", 2'b00, 1'b0, 8'd1, 1'b0, 70, 480, 480, 0);
    slot("R5 reset absent k2", 2'b00, 1'b0, 8'd2, 1'b1, 70, 480, 480, 1);
  endtask

  task automatic t_touch;
    slot("R7 touch1 x1", 2'b11, 1'b1, 8'd2, 1'b1, 9, 6, 64, 1);
    slot("R7 touch1 x0", 2'b11, 1'b1, 8'd1, 1'b0, 9, 6, 64, 0);
    // line idles high (x=0): a sampled touch-0 would give 1
    slot("R7 touch0", 2'b11, 1'b0, 8'd1, 1'b0, 0, 60, 10, 0);
  endtask

  task automatic t_coef;
    slot("R6 coef zero", 2'b01, 1'b1, 8'd0, 1'b0, 0, 6, 64, 0);
    xval = 1'b0;
    smp_at = 0;
    start(2'b01, 1'b1, 8'd2);
    repeat (10) @(negedge clk_i);
    coef_i = 8'd5;
    wait_done();
    chk("R6 coef latched low", low_cnt, 12);
    chk("R6 coef latched rel", rel_cnt, 128);
  endtask

  task automatic t_busy_ignore;
    int seen_ready;
    seen_ready = 0;
    xval = 1'b0;
    smp_at = 0;
    start(2'b01, 1'b0, 8'd1);
    repeat (20) @(negedge clk_i);
    req_kind_i  = 2'b00;
    req_valid_i = 1'b1;
    repeat (10) begin
      @(negedge clk_i);
      seen_ready = seen_ready + int'(req_ready_o);
    end
    req_valid_i = 1'b0;
    chk("R1 ready while busy", seen_ready, 0);
    wait_done();
    chk("R1 ignored low", low_cnt, 60);
    chk("R1 ignored rel", rel_cnt, 10);
    repeat (10) @(negedge clk_i);
    chk("R1 nothing queued", int'(busy_o), 0);
  endtask

  task automatic t_result_hold;
    slot("R8 hold setup", 2'b10, 1'b0, 8'd1, 1'b1, 9, 6, 64, 1);
    xval = 1'b1;  // idle line now low
    repeat (50) @(negedge clk_i);
    chk("R8 result held", int'(result_o), 1);
    chk("R8 done one cycle", int'(done_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset_state();
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    t_writes();
    t_reads();
    t_bus_reset();
    t_touch();
    t_coef();
    t_busy_ignore();
    t_result_hold();
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule